// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a reloading down-counter that produces the periodic tick an operating system schedules on. Software programs a reload value and selects a count source. The source is either the core clock or a slower reference tick that arrives asynchronously on a pin. Once enabled, the counter steps down toward zero. The step after zero refills it from the reload value, so one period spans reload + 1 steps.

Each time the count falls from 1 to 0, a sticky zero flag sets. If interrupts are enabled, a one-cycle interrupt request also pulses. Reading the control/status register returns the flag and clears it. Writing any value to the current-count register zeroes both the counter and the flag. A calibration register is read-only and mirrors three input pin groups: a no-reference indication, an inexact indication and a ten-millisecond count.

Top module: `os_tick_timer`

## Requirements
- R1: After reset, the control, reload and current-count registers read 0 and `tick_irq` is low.
- R2: The register index on `bus_idx` selects the register. Index 0 is control/status, index 1 is reload (bits 23:0), index 2 is current count (bits 23:0) and index 3 is calibration. Unused read bits return 0.
- R3: Control bit 0 enables counting. While it is 0, the current count holds its value.
- R4: Control bit 2 selects the count source. When it is 1, the counter takes one step on every core clock cycle. A step decrements a nonzero count, and a step taken at a count of 0 loads the reload value.
- R5: When control bit 2 is 0, the counter takes one step per rising edge of `ref_tick_in`, after a two-flop synchronizer. It holds its value while that input has no rising edges.
- R6: When control bit 1 is set, `tick_irq` pulses high for exactly one cycle on each 1-to-0 transition of the count. When control bit 1 is clear, it stays low.
- R7: Control/status bit 16 sets on each 1-to-0 transition of the count, in the same cycle as the interrupt pulse, and reads back as 1 until it is cleared.
- R8: A read of control/status clears bit 16. If a 1-to-0 transition happens in the same cycle as that read, the bit stays set.
- R9: A write of any data to the current-count register sets the count to 0 and clears bit 16.
- R10: With a reload value of 0, the count stays at 0 and produces no flag or interrupt.
- R11: The calibration register reads `cal_noref_in` in bit 31, `cal_inexact_in` in bit 30 and `cal_count_in` in bits 23:0, with 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the selected register) |
| ref_tick_in | input | 1 | Asynchronous reference tick |
| cal_noref_in | input | 1 | Calibration: no reference clock available |
| cal_inexact_in | input | 1 | Calibration: ten-millisecond value is inexact |
| cal_count_in | input | 24 | Calibration: ten-millisecond count |
| tick_irq | output | 1 | One-cycle interrupt request |

## Verification
The bench pins down the reload step by timing interrupt pulses. A design that decremented through zero or skipped the load step would show a period other than reload + 1. It also arranges a status read in the same cycle as a 1-to-0 transition: clearing with priority would lose that tick, and the next read would return 0. A reload of 0 is run to catch a design that fires on every step at zero instead of on the transition. The reference-source test counts whole edges and then checks that the count holds while the input stays quiet, so a design that counted the high level, or ran on the core clock anyway, gives the wrong current value.

// File: rtl/os_tick_pkg.sv
package os_tick_pkg;

   localparam int BUS_W = 32;

   typedef enum logic [1:0] {
      IDX_CTRL    = 2'd0,
      IDX_RELOAD  = 2'd1,
      IDX_CURRENT = 2'd2,
      IDX_CALIB   = 2'd3
   } reg_idx_e;

   // control/status bit positions
   localparam int CB_RUN   = 0;
   localparam int CB_IRQEN = 1;
   localparam int CB_CORE  = 2;
   localparam int CB_FLAG  = 16;
   // calibration bit positions
   localparam int KB_NOREF   = 31;
   localparam int KB_INEXACT = 30;

   typedef struct packed {
      logic core_src;
      logic irq_en;
      logic run;
   } tick_ctrl_t;

endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("tick_edge_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];

   assign rise_pulse = chain_q[STAGES-1] & ~last_q;

   // R5
   one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/tick_down_core.sv
module tick_down_core #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             clr,
   input  logic             status_rd,
   input  logic             irq_en,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             flag,
   output logic             irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic zero_evt;

   assign zero_evt = step & ~clr & (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (clr)              count <= '0;
      else if (step) begin
         if (count == '0)        count <= reload;
         else                    count <= count - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flag <= 1'b0;
      else if (zero_evt)             flag <= 1'b1;
      else if (status_rd || clr)     flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) irq <= 1'b0;
      else        irq <= zero_evt & irq_en;

   // R6
   irq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R7
   irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && count == '0));
   // R9
   clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0 && !flag));
   // R10
   zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload == '0 && count == '0) |=> (count == '0 && !irq));
   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(count));

endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer
   import os_tick_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [1:0]       bus_idx,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic             ref_tick_in,
   input  logic             cal_noref_in,
   input  logic             cal_inexact_in,
   input  logic [CNT_W-1:0] cal_count_in,
   output logic             tick_irq
);
   localparam int PAD_CNT = BUS_W - CNT_W;
   localparam int PAD_CAL = BUS_W - 2 - CNT_W;

   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
      $error("os_tick_timer: CNT_W must lie in 2..30");
   end

   tick_ctrl_t       ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count;
   logic             flag;
   logic             ref_rise;
   logic             step;
   logic             wr_ctrl, wr_reload, wr_current, rd_status;

   assign wr_ctrl    = bus_sel &  bus_wr & (bus_idx == IDX_CTRL);
   assign wr_reload  = bus_sel &  bus_wr & (bus_idx == IDX_RELOAD);
   assign wr_current = bus_sel &  bus_wr & (bus_idx == IDX_CURRENT);
   assign rd_status  = bus_sel & ~bus_wr & (bus_idx == IDX_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run      <= bus_wdata[CB_RUN];
            ctrl_q.irq_en   <= bus_wdata[CB_IRQEN];
            ctrl_q.core_src <= bus_wdata[CB_CORE];
         end
         if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
      end
   end

   tick_edge_sync #(.STAGES(SYNC_STAGES)) ref_sync_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (ref_tick_in),
      .rise_pulse (ref_rise)
   );

   assign step = ctrl_q.run & (ctrl_q.core_src | ref_rise);

   tick_down_core #(.CNT_W(CNT_W)) core_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .clr       (wr_current),
      .status_rd (rd_status),
      .irq_en    (ctrl_q.irq_en),
      .reload    (reload_q),
      .count     (count),
      .flag      (flag),
      .irq       (tick_irq)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_idx)
         IDX_CTRL: begin
            bus_rdata[CB_FLAG]  = flag;
            bus_rdata[CB_CORE]  = ctrl_q.core_src;
            bus_rdata[CB_IRQEN] = ctrl_q.irq_en;
            bus_rdata[CB_RUN]   = ctrl_q.run;
         end
         IDX_RELOAD:  bus_rdata = {{PAD_CNT{1'b0}}, reload_q};
         IDX_CURRENT: bus_rdata = {{PAD_CNT{1'b0}}, count};
         IDX_CALIB:   bus_rdata = {cal_noref_in, cal_inexact_in,
                                   {PAD_CAL{1'b0}}, cal_count_in};
         default:     bus_rdata = '0;
      endcase
   end

   // R6
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |-> $past(ctrl_q.irq_en));
   // R3
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !wr_current) |=> $stable(count));
   // R5
   ref_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.run && !ctrl_q.core_src && !ref_rise && !wr_current) |=> $stable(count));

endmodule

// File: tb/os_tick_timer_tb_top.sv
`timescale 1ns/1ps
module os_tick_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_idx = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ref_tick_in = 1'b0;
   logic        cal_noref_in = 1'b0;
   logic        cal_inexact_in = 1'b0;
   logic [23:0] cal_count_in = '0;
   logic        tick_irq;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   os_tick_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ref_tick_in(ref_tick_in), .cal_noref_in(cal_noref_in),
      .cal_inexact_in(cal_inexact_in), .cal_count_in(cal_count_in),
      .tick_irq(tick_irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // drives at a falling edge; the write lands on the following rising edge
   task automatic wr(input logic [1:0] idx, input logic [31:0] data);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_wdata = data;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] idx, output logic [31:0] data);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = idx;
      #1 data = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(2'd0, v); check("R1 control after reset", v, 32'h0);
      rd(2'd1, v); check("R1 reload after reset", v, 32'h0);
      rd(2'd2, v); check("R1 current after reset", v, 32'h0);
      check("R1 irq after reset", {31'b0, tick_irq}, 32'h0);
   endtask

   task automatic t_core_period;
      int pulses = 0; int last = -1; int bad_gap = 0;
      logic [31:0] v;
      wr(2'd0, 32'h0); wr(2'd1, 32'd5); wr(2'd2, 32'h0);
      wr(2'd0, 32'h7);
      for (int k = 1; k <= 30; k++) begin
         @(negedge clk);
         if (tick_irq) begin
            if (last >= 0 && k - last != 6) bad_gap++;
            if (last < 0 && k != 6) bad_gap++;
            last = k; pulses++;
         end
      end
      wr(2'd0, 32'h0);
      check("R4 R6 pulse count core source", pulses, 5);
      check("R4 R6 pulse spacing reload+1", bad_gap, 0);
      rd(2'd1, v); check("R2 reload readback", v, 32'd5);
   endtask

   task automatic t_decrement_and_hold;
      logic [31:0] v;
      wr(2'd1, 32'd100); wr(2'd2, 32'h0); wr(2'd0, 32'h5);
      repeat (3) @(negedge clk);
      rd(2'd2, v); check("R4 decrement value", v, 32'd98);
      wr(2'd0, 32'h4);
      repeat (5) @(negedge clk);
      rd(2'd2, v); check("R3 hold when disabled", v, 32'd96);
      rd(2'd0, v); check("R2 control readback", v, 32'h4);
   endtask

   task automatic t_flag_no_irq;
      int pulses = 0;
      logic [31:0] v;
      wr(2'd0, 32'h0); wr(2'd1, 32'd2); wr(2'd2, 32'h0); wr(2'd0, 32'h5);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (tick_irq) pulses++;
      end
      check("R6 no irq when bit1 clear", pulses, 0);
      rd(2'd0, v); check("R7 flag set after zero", {31'b0, v[16]}, 32'h1);
      rd(2'd0, v); check("R8 flag cleared by read", {31'b0, v[16]}, 32'h0);
      wr(2'd0, 32'h0);
   endtask

   task automatic t_read_coincide;
      logic [31:0] v;
      wr(2'd1, 32'd2); wr(2'd2, 32'h0); wr(2'd0, 32'h5);
      repeat (2) @(negedge clk);
      rd(2'd0, v); check("R8 flag before coinciding event", {31'b0, v[16]}, 32'h0);
      rd(2'd0, v); check("R8 flag kept when read meets event", {31'b0, v[16]}, 32'h1);
      wr(2'd0, 32'h0);
   endtask

   task automatic t_current_write;
      logic [31:0] v;
      wr(2'd1, 32'd2); wr(2'd2, 32'h0); wr(2'd0, 32'h5);
      repeat (6) @(negedge clk);
      wr(2'd0, 32'h0);
      rd(2'd2, v);
      wr(2'd2, 32'h00AB_CDEF);
      rd(2'd2, v); check("R9 current cleared by write", v, 32'h0);
      rd(2'd0, v); check("R9 flag cleared by current write", {31'b0, v[16]}, 32'h0);
   endtask

   task automatic t_ref_source;
      int pulses = 0;
      logic [31:0] v;
      wr(2'd0, 32'h0); wr(2'd1, 32'd3); wr(2'd2, 32'h0); wr(2'd0, 32'h3);
      for (int e = 0; e < 6; e++) begin
         ref_tick_in = 1'b1;
         for (int k = 0; k < 4; k++) begin @(negedge clk); if (tick_irq) pulses++; end
         ref_tick_in = 1'b0;
         for (int k = 0; k < 4; k++) begin @(negedge clk); if (tick_irq) pulses++; end
      end
      for (int k = 0; k < 10; k++) begin @(negedge clk); if (tick_irq) pulses++; end
      check("R5 R6 irq count on reference edges", pulses, 1);
      rd(2'd2, v); check("R5 count after six edges", v, 32'd2);
      repeat (20) @(negedge clk);
      rd(2'd2, v); check("R5 hold without edges", v, 32'd2);
      wr(2'd0, 32'h0);
   endtask

   task automatic t_zero_reload;
      int pulses = 0;
      logic [31:0] v;
      wr(2'd1, 32'd0); wr(2'd2, 32'h0); wr(2'd0, 32'h7);
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (tick_irq) pulses++; end
      check("R10 no irq with zero reload", pulses, 0);
      rd(2'd2, v); check("R10 count stays zero", v, 32'h0);
      rd(2'd0, v); check("R10 flag stays clear", {31'b0, v[16]}, 32'h0);
      wr(2'd0, 32'h0);
   endtask

   task automatic t_calib;
      logic [31:0] v;
      cal_noref_in = 1'b1; cal_inexact_in = 1'b0; cal_count_in = 24'h0F423F;
      rd(2'd3, v); check("R11 calibration pattern A", v, 32'h800F_423F);
      cal_noref_in = 1'b0; cal_inexact_in = 1'b1; cal_count_in = 24'hFFFFFF;
      rd(2'd3, v); check("R11 calibration pattern B", v, 32'h40FF_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_core_period();
      t_decrement_and_hold();
      t_flag_no_irq();
      t_read_coincide();
      t_current_write();
      t_ref_source();
      t_zero_reload();
      t_calib();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule